// File: doc/BRIEF.md
# Gated Interrupt Status Controller

The block gathers single-cycle event pulses from 24 internal sources, arranged as three groups of eight. Each group owns an enable register and a status register. A pulse is captured into its status bit only when the matching enable bit is already set. Once a status bit is captured, it stays set until software clears it. The single active-low interrupt output is low whenever any captured status bit is set.

Software reaches the six registers through a simple port made of a byte address, byte write data, a write strobe and combinational read data. Enable registers are plain read/write registers. Status registers clear bit by bit: writing a 1 to a bit clears it. This lets a handler acknowledge one source without disturbing the other pending sources.

Top module: `irq_gather`

## Requirements
- R1: After reset every enable and status bit reads 0 and `irq_n` is 1.
- R2: Address 0x00+g reads and writes the enable register of group g, and address 0x04+g reads the status register of group g, for g = 0..2. Bit i of group g belongs to source `evt_i[8*g+i]`. Reads of any other address return 0, and writes to any other address change no register.
- R3: A pulse on a source sets its status bit at the next clock edge only if its enable bit is 1 in the cycle of the pulse. An enable written in that same cycle takes effect from the following cycle.
- R4: `irq_n` is 0 exactly when at least one status bit is 1. It changes at the same clock edge as the status bits.
- R5: In a write to a status address, each 1 in `wr_data` clears that status bit and each 0 leaves it unchanged.
- R6: If a clear and an enabled event hit the same status bit in the same cycle, the bit ends up set.
- R7: Writing an enable bit to 0 leaves an already-set status bit set.
- R8: `rd_data` shows the register selected by `addr` in the same cycle, and reading has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Single-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench targets four corner cases:
- An event that arrives while its enable is 0. A design that gated the output instead of the capture would latch the event and then assert the interrupt as soon as the enable rises.
- An event and a clear of the same bit in the same cycle. A design where the clear wins would lose that event.
- Writes of zeros to a status register, and writes to unmapped addresses. Either would wipe pending bits in a design with a careless decode.
- Dropping an enable while its status bit is pending. A design that tied status to enable would release the interrupt without software acknowledging it.

A long stretch of mixed traffic across all addresses then checks every read and the interrupt line against the model on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int GRP_W   = 8;
    localparam int NUM_GRP = 3;
    localparam int ADDR_W  = 8;
    localparam int EN_BASE = 0;
    localparam int ST_BASE = 4;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W = irq_pkg::GRP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         en_we,
    input  logic         st_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] status_nxt,
    output logic [W-1:0] enable
);
    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] enable;
    } grp_t;

    grp_t         grp_d, grp_q;
    logic [W-1:0] clr_mask;
    logic [W-1:0] set_mask;

    always_comb begin
        grp_d    = grp_q;
        clr_mask = st_we ? wdata : '0;
        set_mask = evt & grp_q.enable;
        // The set term is applied last, so a new event beats a clear.
        grp_d.status = (grp_q.status & ~clr_mask) | set_mask;
        if (en_we) begin
            grp_d.enable = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign status     = grp_q.status;
    assign enable     = grp_q.enable;
    assign status_nxt = grp_d.status;

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(enable)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & enable) != '0) |=> ((status & $past(evt & enable)) == $past(evt & enable)));

    assert_w0_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> (($past(status) & ~$past(wdata) & ~status) == '0));

    assert_only_w1c_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> (($past(status) & ~status) == '0));
endmodule

// File: rtl/irq_regport.sv
module irq_regport #(
    parameter int W       = irq_pkg::GRP_W,
    parameter int N       = irq_pkg::NUM_GRP,
    parameter int AW      = irq_pkg::ADDR_W,
    parameter int EN_BASE = irq_pkg::EN_BASE,
    parameter int ST_BASE = irq_pkg::ST_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic [N-1:0][W-1:0] status,
    input  logic [N-1:0][W-1:0] enable,
    output logic [N-1:0]        en_we,
    output logic [N-1:0]        st_we,
    output logic [W-1:0]        rd_data
);
    logic [N-1:0] en_hit;
    logic [N-1:0] st_hit;

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < N; g++) begin
            en_hit[g] = (int'(addr) == EN_BASE + g);
            st_hit[g] = (int'(addr) == ST_BASE + g);
            if (en_hit[g]) rd_data = enable[g];
            if (st_hit[g]) rd_data = status[g];
        end
        en_we = en_hit & {N{wr_en}};
        st_we = st_hit & {N{wr_en}};
    end

    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_we, st_we}));
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter int GRP_W   = irq_pkg::GRP_W,
    parameter int NUM_GRP = irq_pkg::NUM_GRP,
    parameter int ADDR_W  = irq_pkg::ADDR_W,
    parameter int EN_BASE = irq_pkg::EN_BASE,
    parameter int ST_BASE = irq_pkg::ST_BASE,
    localparam int SRC_N  = GRP_W * NUM_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GRP_W-1:0]  wr_data,
    output logic [GRP_W-1:0]  rd_data,
    output logic              irq_n
);
    typedef struct packed {
        logic irq_n;
    } out_t;

    logic [NUM_GRP-1:0][GRP_W-1:0] status, status_nxt, enable;
    logic [NUM_GRP-1:0]            en_we, st_we;
    out_t                          out_d, out_q;

    irq_regport #(
        .W(GRP_W), .N(NUM_GRP), .AW(ADDR_W), .EN_BASE(EN_BASE), .ST_BASE(ST_BASE)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .status(status), .enable(enable),
        .en_we(en_we), .st_we(st_we), .rd_data(rd_data)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_group #(.W(GRP_W)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .evt(evt_i[g*GRP_W +: GRP_W]),
            .en_we(en_we[g]), .st_we(st_we[g]), .wdata(wr_data),
            .status(status[g]), .status_nxt(status_nxt[g]), .enable(enable[g])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.irq_n = ~|status_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{irq_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_n = out_q.irq_n;

    assert_irq_nor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == ~|status);
endmodule

// File: tb/tb_irq_gather.sv
`timescale 1ns/1ps
module tb_irq_gather;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int m_en [3];
    int m_st [3];

    always #2 clk = ~clk;

    irq_gather dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic int model_read(input int a);
        if (a >= 0 && a < 3) return m_en[a];
        if (a >= 4 && a < 7) return m_st[a-4];
        return 0;
    endfunction

    function automatic int model_irq_n();
        return (m_st[0] | m_st[1] | m_st[2]) != 0 ? 0 : 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: drive, compare the read, advance.
    task automatic step(input string tag, input logic [23:0] ev, input bit we,
                        input int a, input int wd);
        int clr;
        evt_i = ev; wr_en = we; addr = 8'(a); wr_data = 8'(wd);
        #1;
        check({tag, " rd_data"}, int'(rd_data), model_read(a));
        for (int g = 0; g < 3; g++) begin
            clr = (we && a == 4 + g) ? wd : 0;
            m_st[g] = ((m_st[g] & ~clr) | (int'(ev[g*8 +: 8]) & m_en[g])) & 8'hff;
        end
        for (int g = 0; g < 3; g++) begin
            if (we && a == g) m_en[g] = wd & 8'hff;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " irq_n"}, int'(irq_n), model_irq_n());
    endtask

    task automatic idle_read(input string tag, input int a);
        step(tag, 24'h0, 1'b0, a, 8'h00);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 3; g++) begin m_en[g] = 0; m_st[g] = 0; end
        repeat (3) @(negedge clk);
        check("R1 irq_n in reset", int'(irq_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) idle_read("R1 reset value", a);

        // R3: an event with its enable at 0 is dropped
        step("R3 disabled event", 24'hffffff, 1'b0, 4, 0);
        for (int a = 4; a < 7; a++) idle_read("R3 nothing latched", a);

        // R2: enable write/readback, unmapped writes ignored
        step("R2 en0 write", 24'h0, 1'b1, 0, 8'h5a);
        step("R2 en1 write", 24'h0, 1'b1, 1, 8'hff);
        step("R2 en2 write", 24'h0, 1'b1, 2, 8'h81);
        step("R2 unmapped 3", 24'h0, 1'b1, 3, 8'hff);
        step("R2 unmapped 7", 24'h0, 1'b1, 7, 8'hff);
        step("R2 unmapped 80", 24'h0, 1'b1, 8'h80, 8'hff);
        for (int a = 0; a < 8; a++) idle_read("R2 readback", a);

        // R3: enable written in same cycle as event does not gate it yet
        step("R3 same-cycle enable", 24'h000080, 1'b1, 0, 8'hda);
        idle_read("R3 late enable", 4);
        step("R3 gated capture", 24'h8100ff, 1'b0, 4, 0);
        for (int a = 4; a < 7; a++) idle_read("R3 captured", a);

        // R8: repeated reads change nothing
        for (int k = 0; k < 4; k++) idle_read("R8 stable read", 5);

        // R5: zeros keep bits, ones clear them
        step("R5 write zeros", 24'h0, 1'b1, 4, 8'h00);
        idle_read("R5 zeros kept", 4);
        step("R5 clear bit1", 24'h0, 1'b1, 4, 8'h02);
        idle_read("R5 one cleared", 4);
        step("R5 clear grp1", 24'h0, 1'b1, 5, 8'hff);
        idle_read("R5 grp1 empty", 5);

        // R6: set beats clear on the same bit
        step("R6 set vs clear", 24'h000008, 1'b1, 4, 8'h08);
        idle_read("R6 set kept", 4);

        // R7: dropping enable keeps pending status
        step("R7 en2 off", 24'h0, 1'b1, 2, 8'h00);
        idle_read("R7 status kept", 6);
        step("R7 event while off", 24'h810000, 1'b0, 6, 0);
        step("R4 clear grp2", 24'h0, 1'b1, 6, 8'hff);
        step("R4 clear grp0", 24'h0, 1'b1, 4, 8'hff);
        for (int a = 4; a < 7; a++) idle_read("R4 all clear", a);

        // Mixed traffic, R3 R4 R5 R6 R8
        for (int k = 0; k < 3000; k++) begin
            logic [23:0] ev;
            ev = 24'($urandom) & 24'($urandom) & 24'($urandom);
            step("R4 mixed", ev, ($urandom % 3) == 0, int'($urandom % 8),
                 int'($urandom % 256));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule